// File: doc/BRIEF.md
# Foldback PWM Oscillator with Jitter

This block produces the switching cadence for a peak-current-mode power converter. It takes a feedback-voltage code in millivolts and turns it into a switching period, a gate-enable window and a peak-current setpoint code. When the feedback code is high, the block runs at a nominal frequency. That frequency is chosen by one input between 65 kHz and 100 kHz. As the load falls, the feedback code falls too, and the period stretches linearly toward a 26 kHz floor. Below a freeze level the setpoint code stops following the feedback. At the very lowest feedback levels the block suppresses whole cycles, with hysteresis on the decision.

All periods are counts of a 100 MHz system clock. A triangular up/down phase counter adds an offset of up to ±5% of the current period. This jitter applies in normal mode and in foldback mode alike. A new period is latched only at a cycle boundary. The gate window closes at 80% of the latched period.

Top module: `foldback_osc`

## Requirements
- R1: With fb_mv >= 1500 and zero jitter phase, cycle strobes are spaced 1538 clocks apart when sel_fast = 0 and 1000 clocks apart when sel_fast = 1.
- R2: For 350 < fb_mv < 1500 the period is P = F - floor((F - N) * (fb_mv - 350) / 1150). Here F = 3846 and N is the nominal count from R1.
- R3: For fb_mv <= 350 and outside skip, the period is the floor count of 3846 clocks (26 kHz).
- R4: For fb_mv >= 1050, setpt_mv equals floor(fb_mv * 10 / 42), capped at 800.
- R5: For fb_mv < 1050, setpt_mv is frozen at 250.
- R6: When fb_mv drops below 300, skipping goes to 1. While skipping, no cycle strobe occurs and gate_en stays 0.
- R7: Once skipping, the flag stays set while fb_mv < 330 and clears when fb_mv >= 330. Coming from above, fb_mv between 300 and 329 does not set it. After release, cycles resume at the next boundary.
- R8: In each started cycle of period P, gate_en is high for exactly floor(P * 80 / 100) clocks, starting on the clock of the cycle strobe.
- R9: A change of fb_mv in the middle of a cycle does not change that cycle's length. The new period applies from the next cycle.
- R10: The jitter phase walks a triangle. Each period stays within ±5% of the unjittered period, and periods both above and below it occur.
- R11: During reset, cyc_start = 0, gate_en = 0, skipping = 0 and setpt_mv = 250.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fb_mv | input | 12 | Feedback voltage code in mV |
| sel_fast | input | 1 | 1 selects the 100 kHz nominal, 0 selects 65 kHz |
| cyc_start | output | 1 | One-clock strobe at the start of each switching cycle |
| gate_en | output | 1 | Gate window, closed at the maximum duty point |
| setpt_mv | output | 10 | Peak-current setpoint code in mV |
| skipping | output | 1 | High while cycles are being skipped |

## Verification
The bench targets the edges of the piecewise map: exactly 1500 mV, exactly 350 mV, the 1050 mV freeze knee and the 800 mV cap. If the map is off by one segment, the measured spacing between strobes shows it. It enters the skip band from above and sits at 315 mV and 329 mV to prove the hysteresis holds. A design with a single threshold would chatter there or release early. It changes the feedback right after a strobe; a design that reloads the period mid-cycle would cut that cycle short. A second instance with a fast jitter tick checks that foldback periods stay inside the ±5% band and swing to both sides.

// File: rtl/osc_pkg.sv
package osc_pkg;

  // Period in clocks as a function of the feedback code (piecewise-linear).
  function automatic int fold_period(int fb, int nom, int pmax, int f_hi, int f_lo);
    if (fb >= f_hi) return nom;
    if (fb <= f_lo) return pmax;
    return pmax - ((pmax - nom) * (fb - f_lo)) / (f_hi - f_lo);
  endfunction

  // Peak-current setpoint: feedback / 4.2, capped, frozen below the knee.
  function automatic int setpoint(int fb, int knee, int cap);
    int v;
    if (fb < knee) return (knee * 10) / 42;
    v = (fb * 10) / 42;
    return (v > cap) ? cap : v;
  endfunction

  // Gate-window length for a given period.
  function automatic int on_limit(int per, int duty_pct);
    return (per * duty_pct) / 100;
  endfunction

  // Signed jitter offset: phase/steps of a 5% swing.
  function automatic int jit_offset(int base, int phase, int steps);
    return (base * phase) / (20 * steps);
  endfunction

endpackage

// File: rtl/fold_map.sv
module fold_map
  import osc_pkg::*;
#(
  parameter int FB_W       = 12,
  parameter int SP_W       = 10,
  parameter int PER_W      = 13,
  parameter int NOM_LO     = 1538,
  parameter int NOM_HI     = 1000,
  parameter int PER_MAX    = 3846,
  parameter int FOLD_MV    = 1500,
  parameter int FOLD_END   = 350,
  parameter int FREEZE_MV  = 1050,
  parameter int ISET_CAP   = 800,
  parameter int SKIP_MV    = 300,
  parameter int SKIP_HYS   = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FB_W-1:0]  fb_mv,
  input  logic             sel_fast,
  output logic [PER_W-1:0] base_per,
  output logic [SP_W-1:0]  setpt_q,
  output logic             skip_q
);

  localparam int FROZEN_SP = (FREEZE_MV * 10) / 42;
  localparam int RELEASE_MV = SKIP_MV + SKIP_HYS;

  logic [PER_W-1:0] nom_per;
  logic             skip_d;

  assign nom_per  = sel_fast ? PER_W'(NOM_HI) : PER_W'(NOM_LO);
  assign base_per = PER_W'(fold_period(int'(fb_mv), int'(nom_per), PER_MAX,
                                       FOLD_MV, FOLD_END));
  assign skip_d   = skip_q ? (int'(fb_mv) < RELEASE_MV) : (int'(fb_mv) < SKIP_MV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setpt_q <= SP_W'(FROZEN_SP);
      skip_q  <= 1'b0;
    end else begin
      setpt_q <= SP_W'(setpoint(int'(fb_mv), FREEZE_MV, ISET_CAP));
      skip_q  <= skip_d;
    end
  end

  // R4
  setpt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(setpt_q) >= FROZEN_SP) && (int'(setpt_q) <= ISET_CAP));

  // R6
  skip_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fb_mv) < SKIP_MV) |=> skip_q);

  // R7
  skip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_q && int'(fb_mv) < RELEASE_MV) |=> skip_q);

  // R3
  per_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(base_per) <= PER_MAX) && (int'(base_per) >= NOM_HI));

endmodule

// File: rtl/jitter_gen.sv
module jitter_gen #(
  parameter int STEPS = 32,
  parameter int TICK  = 3255,
  parameter int PH_W  = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic signed [PH_W-1:0] phase_q
);

  localparam int TK_W = (TICK > 1) ? $clog2(TICK) : 1;

  logic [TK_W-1:0] tick_q;
  logic            up_q;
  logic            tick_hit;

  assign tick_hit = (int'(tick_q) == TICK - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q  <= '0;
      up_q    <= 1'b1;
      phase_q <= '0;
    end else if (tick_hit) begin
      tick_q <= '0;
      if (up_q) begin
        if (int'(phase_q) >= STEPS) begin
          up_q    <= 1'b0;
          phase_q <= phase_q - PH_W'(1);
        end else begin
          phase_q <= phase_q + PH_W'(1);
        end
      end else begin
        if (int'(phase_q) <= -STEPS) begin
          up_q    <= 1'b1;
          phase_q <= phase_q + PH_W'(1);
        end else begin
          phase_q <= phase_q - PH_W'(1);
        end
      end
    end else begin
      tick_q <= tick_q + TK_W'(1);
    end
  end

  // R10
  jit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(phase_q) <= STEPS) && (int'(phase_q) >= -STEPS));

  // R10
  jit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(phase_q) - int'($past(phase_q))) <= 1) &&
    ((int'(phase_q) - int'($past(phase_q))) >= -1));

endmodule

// File: rtl/cycle_timer.sv
module cycle_timer
  import osc_pkg::*;
#(
  parameter int PER_W    = 13,
  parameter int DUTY_PCT = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] next_per,
  input  logic             skip_i,
  output logic             cyc_start,
  output logic             gate_en,
  output logic [PER_W-1:0] per_q
);

  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] lim_q;
  logic             run_q;
  logic             boundary;

  assign boundary  = (cnt_q >= per_q - PER_W'(1));
  assign cyc_start = run_q && (cnt_q == '0);
  assign gate_en   = run_q && (cnt_q < lim_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= PER_W'(1);
      lim_q <= '0;
      run_q <= 1'b0;
    end else if (boundary) begin
      cnt_q <= '0;
      per_q <= next_per;
      lim_q <= PER_W'(on_limit(int'(next_per), DUTY_PCT));
      run_q <= !skip_i;
    end else begin
      cnt_q <= cnt_q + PER_W'(1);
    end
  end

  // R6
  no_start_in_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> !$past(skip_i));

  // R8
  gate_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en) |-> cyc_start);

  // R9
  per_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> $stable(per_q));

endmodule

// File: rtl/foldback_osc.sv
module foldback_osc
  import osc_pkg::*;
#(
  parameter int CLK_HZ     = 100_000_000,
  parameter int F_NOM_LO   = 65_000,
  parameter int F_NOM_HI   = 100_000,
  parameter int F_MIN      = 26_000,
  parameter int FB_W       = 12,
  parameter int SP_W       = 10,
  parameter int JIT_RATE   = 240,
  parameter int JIT_STEPS  = 32,
  parameter int JIT_TICK   = CLK_HZ / (JIT_RATE * 4 * JIT_STEPS),
  parameter int DUTY_PCT   = 80
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FB_W-1:0] fb_mv,
  input  logic            sel_fast,
  output logic            cyc_start,
  output logic            gate_en,
  output logic [SP_W-1:0] setpt_mv,
  output logic            skipping
);

  localparam int NOM_LO  = CLK_HZ / F_NOM_LO;
  localparam int NOM_HI  = CLK_HZ / F_NOM_HI;
  localparam int PER_MAX = CLK_HZ / F_MIN;
  localparam int PER_W   = $clog2(PER_MAX + PER_MAX / 20 + 2);
  localparam int PH_W    = $clog2(JIT_STEPS + 1) + 1;

  logic [PER_W-1:0]        base_per;
  logic [PER_W-1:0]        next_per;
  logic [PER_W-1:0]        live_per;
  logic signed [PH_W-1:0]  jit_ph;

  fold_map #(
    .FB_W(FB_W), .SP_W(SP_W), .PER_W(PER_W),
    .NOM_LO(NOM_LO), .NOM_HI(NOM_HI), .PER_MAX(PER_MAX),
    .FOLD_MV(1500), .FOLD_END(350), .FREEZE_MV(1050),
    .ISET_CAP(800), .SKIP_MV(300), .SKIP_HYS(30)
  ) u_map (
    .clk(clk), .rst_n(rst_n), .fb_mv(fb_mv), .sel_fast(sel_fast),
    .base_per(base_per), .setpt_q(setpt_mv), .skip_q(skipping)
  );

  jitter_gen #(.STEPS(JIT_STEPS), .TICK(JIT_TICK), .PH_W(PH_W)) u_jit (
    .clk(clk), .rst_n(rst_n), .phase_q(jit_ph)
  );

  assign next_per = PER_W'(int'(base_per) +
                           jit_offset(int'(base_per), int'(jit_ph), JIT_STEPS));

  cycle_timer #(.PER_W(PER_W), .DUTY_PCT(DUTY_PCT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .next_per(next_per), .skip_i(skipping),
    .cyc_start(cyc_start), .gate_en(gate_en), .per_q(live_per)
  );

  // R10
  per_jit_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> (int'(live_per) * 20 <= PER_MAX * 21) &&
                  (int'(live_per) * 20 >= NOM_HI * 19));

  // R8
  start_opens_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> gate_en);

endmodule

// File: tb/foldback_osc_tb.sv
module foldback_osc_tb;

  localparam int CLK_PERIOD_NS = 10;
  localparam int NV = 9;
  localparam int VEC_SEL [NV] = '{0, 1, 0, 1, 0, 1, 0, 0, 0};
  localparam int VEC_FB  [NV] = '{2000, 2000, 3500, 1500, 1000, 1000, 600, 350, 320};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] fb_mv = 12'd2000;
  logic sel_fast = 1'b0;
  logic cyc_start, gate_en, skipping;
  logic [9:0] setpt_mv;

  logic j_start, j_gate, j_skip;
  logic [9:0] j_sp;

  int n_tests = 0;
  int n_fail = 0;
  bit jit_done = 1'b0;

  always #(CLK_PERIOD_NS / 2) clk = ~clk;

  foldback_osc #(.JIT_TICK(1_000_000)) u_dut (
    .clk(clk), .rst_n(rst_n), .fb_mv(fb_mv), .sel_fast(sel_fast),
    .cyc_start(cyc_start), .gate_en(gate_en), .setpt_mv(setpt_mv), .skipping(skipping)
  );

  foldback_osc #(.JIT_STEPS(4), .JIT_TICK(100)) u_jit (
    .clk(clk), .rst_n(rst_n), .fb_mv(12'd1000), .sel_fast(1'b0),
    .cyc_start(j_start), .gate_en(j_gate), .setpt_mv(j_sp), .skipping(j_skip)
  );

  function automatic int exp_per(int sel, int fb);
    int nom, fl;
    nom = sel ? 100_000_000 / 100_000 : 100_000_000 / 65_000;
    fl  = 100_000_000 / 26_000;
    if (fb >= 1500) return nom;
    if (fb <= 350) return fl;
    return (fl * 1150 - (fl - nom) * (fb - 350) + 1149) / 1150;
  endfunction

  function automatic int exp_sp(int fb);
    int v;
    if (fb < 1050) return 250;
    v = (fb * 5) / 21;
    return (v > 800) ? 800 : v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic meas(output int per, output int on);
    int guard;
    guard = 0;
    @(negedge clk);
    while (!cyc_start && guard < 10000) begin
      @(negedge clk);
      guard++;
    end
    per = 0;
    on = 0;
    do begin
      if (gate_en) on++;
      per++;
      @(negedge clk);
    end while (!cyc_start && per < 10000);
  endtask

  // Jitter observation on the second instance (foldback region, fb = 1000)
  initial begin : jit_obs
    int base, lo, hi, per, n_lo, n_hi, n_bad;
    base = exp_per(0, 1000);
    lo = base - (base * 5) / 100;
    hi = base + (base * 5) / 100;
    n_lo = 0; n_hi = 0; n_bad = 0;
    wait (rst_n);
    @(negedge clk);
    while (!j_start) @(negedge clk);
    for (int k = 0; k < 25; k++) begin
      per = 0;
      do begin
        per++;
        @(negedge clk);
      end while (!j_start && per < 10000);
      if (per < lo || per > hi) n_bad++;
      if (per < base) n_lo++;
      if (per > base) n_hi++;
    end
    check(n_bad == 0, "R10 band", n_bad, 0);
    check(n_lo > 0, "R10 below", n_lo, 1);
    check(n_hi > 0, "R10 above", n_hi, 1);
    jit_done = 1'b1;
  end

  initial begin : watchdog
    repeat (190_000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    int per, on, seen;
    // R11 reset state
    repeat (3) @(negedge clk);
    check(!cyc_start, "R11 strobe", cyc_start, 0);
    check(!gate_en, "R11 gate", gate_en, 0);
    check(!skipping, "R11 skip", skipping, 0);
    check(setpt_mv == 10'd250, "R11 setpt", setpt_mv, 250);
    rst_n = 1'b1;

    // Vector table: R1 R2 R3 R4 R5 R8
    for (int i = 0; i < NV; i++) begin
      sel_fast = VEC_SEL[i][0];
      fb_mv = 12'(VEC_FB[i]);
      meas(per, on);
      meas(per, on);
      check(per == exp_per(VEC_SEL[i], VEC_FB[i]),
            (VEC_FB[i] >= 1500) ? "R1 period" : (VEC_FB[i] <= 350) ? "R3 period" : "R2 period",
            per, exp_per(VEC_SEL[i], VEC_FB[i]));
      check(on == (exp_per(VEC_SEL[i], VEC_FB[i]) * 8) / 10, "R8 on-time",
            on, (exp_per(VEC_SEL[i], VEC_FB[i]) * 8) / 10);
      check(int'(setpt_mv) == exp_sp(VEC_FB[i]),
            (VEC_FB[i] >= 1050) ? "R4 setpt" : "R5 setpt", setpt_mv, exp_sp(VEC_FB[i]));
      check(!skipping, "R7 no skip from above", skipping, 0);
    end

    // R9: change mid-cycle, current cycle keeps its length
    sel_fast = 1'b0;
    fb_mv = 12'd2000;
    meas(per, on);
    meas(per, on);
    @(negedge clk);
    while (!cyc_start) @(negedge clk);
    fb_mv = 12'd600;
    per = 0;
    do begin
      per++;
      @(negedge clk);
    end while (!cyc_start && per < 10000);
    check(per == exp_per(0, 2000), "R9 hold", per, exp_per(0, 2000));
    per = 0;
    do begin
      per++;
      @(negedge clk);
    end while (!cyc_start && per < 10000);
    check(per == exp_per(0, 600), "R9 next", per, exp_per(0, 600));

    // R6 skip entry
    fb_mv = 12'd250;
    repeat (2 * 3846 + 10) @(negedge clk);
    seen = 0;
    for (int c = 0; c < 5000; c++) begin
      if (cyc_start || gate_en) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R6 no cycles", seen, 0);
    check(skipping, "R6 flag", skipping, 1);

    // R7 hysteresis band
    fb_mv = 12'd315;
    seen = 0;
    for (int c = 0; c < 5000; c++) begin
      if (cyc_start || !skipping) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R7 hold 315", seen, 0);
    fb_mv = 12'd329;
    repeat (4) @(negedge clk);
    check(skipping, "R7 hold 329", skipping, 1);
    fb_mv = 12'd330;
    repeat (2) @(negedge clk);
    check(!skipping, "R7 release", skipping, 0);
    seen = 0;
    for (int c = 0; c < 3900 && seen == 0; c++) begin
      if (cyc_start) seen = 1;
      @(negedge clk);
    end
    check(seen == 1, "R7 resume", seen, 1);

    wait (jit_done);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule